// File: doc/BRIEF.md
# DRAM Strobe-Sequence Mode Decoder

This block sits on the device side of an asynchronous DRAM interface, for example inside a behavioural memory model or a bus protocol monitor. It samples the row strobe, the two column strobes (low byte and high byte), the write strobe and the output-enable strobe on a fast reference clock. From the order in which these strobes become active it works out which device operation each memory cycle is. That operation cannot be found from the levels at one instant. Examples are column-before-row refresh against a normal access, and a write requested before the column strobe against one requested after it.

While a cycle runs, the decoder gives a live operation code, the byte lanes that take part, and for each lane whether the data bus should be driven with read data or sampled as write data. It latches the row address when the row strobe falls and the column address at each fresh column-strobe fall. When the row strobe rises it issues a one-cycle report carrying the final operation code and the latched addresses. A column strobe that is pulsed and released with no row strobe is reported as an illegal sequence.

All strobe inputs are active low. They pass through a two-stage synchronizer before decoding, so every response comes three reference-clock edges after the input change.

Top module: `dram_strobe_decoder`

## Requirements
- R1: While the row strobe is inactive, `cur_op` reads standby (code 0) and `dq_oe` and `dq_din` are both zero, whatever the other strobes do.
- R2: A row strobe that falls and rises again with no column strobe active produces a report with code 5, the row address present when the row strobe fell, and a column field of zero.
- R3: A column strobe that is active before the row strobe falls (and was not held over from a read) makes a column-before-row refresh: live code 6, report code 6 with row and column fields zero whatever the address inputs hold, and no lane driven or sampled.
- R4: A column strobe falling after the row strobe, with write inactive, gives a read: live code 1, and `dq_oe[i]` is set for each lane whose column strobe is active while output enable is active.
- R5: Write active at or before the column-strobe fall gives an early write: live code 2, `dq_oe` zero, and `dq_din[i]` set for each active lane.
- R6: Write becoming active after the column strobe fell, with output enable never active in the cycle, gives a delayed write: live code 3, with `dq_oe` zero.
- R7: Output enable active in a read and write becoming active later in the same cycle gives a read-modify-write: lanes are driven (`dq_oe`) before write is active, and after it the live code is 4, `dq_oe` is zero and `dq_din` follows the active lanes.
- R8: Cycling the row strobe while the column strobe stays active from a preceding read gives a hidden refresh: live code 7, output still driven on active lanes with output enable, report code 7 with zero address fields, and no error when the column strobe is released afterwards.
- R9: Lane 0 (bit 0) follows only the low column strobe and lane 1 (bit 1) only the high column strobe; a lane with an inactive strobe has `lane_en`, `dq_oe` and `dq_din` low.
- R10: A column strobe that becomes active and is fully released while the row strobe stays inactive produces a report with error code 15.
- R11: `rpt_valid` is high for exactly one clock per cycle, at the end of the row-strobe low period (or at the error), and for reads and writes carries the row address latched at row fall and the column address latched at the most recent column fall.
- R12: After the row strobe falls and before any column strobe, `cur_op` reads row-open (code 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Low-byte column strobe, active low |
| ucas_n | input | 1 | High-byte column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cur_op | output | 4 | Live operation code |
| lane_en | output | 2 | Lanes taking part (bit 0 low byte) |
| dq_oe | output | 2 | Per-lane drive of read data |
| dq_din | output | 2 | Per-lane write data valid |
| rpt_valid | output | 1 | One-cycle end-of-cycle report strobe |
| rpt_op | output | 4 | Reported operation code |
| rpt_row | output | ROW_W | Reported row address |
| rpt_col | output | COL_W | Reported column address |

## Verification
Two functions can fall on the same decoder clock. The end-of-cycle report for a read can coincide with the start of hidden-refresh tracking, and the column-strobe fall can coincide with the write strobe. The bench raises the row strobe while the column strobes stay low after a read, then checks that the report says read while the live code drops to standby. A second row-strobe fall must then show hidden refresh and not a column-before-row refresh. It also drives write and the column strobes on the same edge and expects early write, not a read that turns into a delayed write.

// File: rtl/dsd_pkg.sv
// Shared operation codes and sequencer states for the strobe decoder.
// Assumes: 4-bit operation field shared by live and reported outputs.
package dsd_pkg;

    typedef enum logic [3:0] {
        OP_STANDBY  = 4'd0,
        OP_READ     = 4'd1,
        OP_EWRITE   = 4'd2,
        OP_DWRITE   = 4'd3,
        OP_RMW      = 4'd4,
        OP_RAS_ONLY = 4'd5,
        OP_CBR      = 4'd6,
        OP_HIDDEN   = 4'd7,
        OP_ROW_OPEN = 4'd8,
        OP_ERROR    = 4'd15
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_READ,
        ST_EWR,
        ST_DWR,
        ST_RMW,
        ST_CAS_PRE,
        ST_CAS_HOLD,
        ST_CBR,
        ST_HIDDEN
    } state_e;

endpackage

// File: rtl/dsd_sync.sv
// Two-stage synchronizer, one chain per bit.
// Assumes: inputs are quasi-static relative to the reference clock;
// RST_VAL gives the inactive level loaded by reset.
module dsd_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int STAGES = 2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw input through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end

        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/dsd_seq_fsm.sv
// Strobe-order sequencer: classifies each memory cycle from the order
// in which the synchronized strobes become active, and issues the
// end-of-cycle report strobe and code.
// Assumes: inputs are already synchronized and active-high.
module dsd_seq_fsm
    import dsd_pkg::*;
#(
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_a,
    input  logic [NL-1:0] cas_a,
    input  logic          we_a,
    input  logic          oe_a,
    output op_e           cur_op,
    output logic          row_take,
    output logic          col_take,
    output logic          st_col,
    output logic          st_out,
    output logic          st_in,
    output logic          rpt_fire,
    output op_e           rpt_op_nxt,
    output logic          rpt_valid,
    output op_e           rpt_op
);

    state_e st, st_n;
    logic   hid, hid_n;
    logic   oe_seen, oes_n;
    logic   cas_prev;
    logic   any_cas;

    assign any_cas = |cas_a;

    // Next-state, report and latch-enable decode from state and strobes.
    always_comb begin
        st_n       = st;
        hid_n      = hid;
        oes_n      = oe_seen;
        rpt_fire   = 1'b0;
        rpt_op_nxt = OP_STANDBY;
        row_take   = 1'b0;
        col_take   = 1'b0;
        case (st)
            ST_IDLE: begin
                if (ras_a) begin
                    st_n     = ST_ROW;
                    row_take = 1'b1;
                    oes_n    = 1'b0;
                end else if (any_cas) begin
                    st_n = ST_CAS_PRE;
                end
            end
            ST_ROW: begin
                if (!ras_a) begin
                    rpt_fire   = 1'b1;
                    rpt_op_nxt = OP_RAS_ONLY;
                    hid_n      = 1'b0;
                    st_n       = any_cas ? ST_CAS_HOLD : ST_IDLE;
                end else if (any_cas) begin
                    col_take = 1'b1;
                    oes_n    = oe_a;
                    st_n     = we_a ? ST_EWR : ST_READ;
                end
            end
            ST_READ: begin
                if (!ras_a) begin
                    rpt_fire   = 1'b1;
                    rpt_op_nxt = OP_READ;
                    hid_n      = 1'b1;
                    st_n       = any_cas ? ST_CAS_HOLD : ST_IDLE;
                end else if (we_a) begin
                    st_n = (oe_seen || oe_a) ? ST_RMW : ST_DWR;
                end else begin
                    oes_n    = oe_seen | oe_a;
                    col_take = any_cas & ~cas_prev;
                end
            end
            ST_EWR, ST_DWR, ST_RMW: begin
                if (!ras_a) begin
                    rpt_fire   = 1'b1;
                    rpt_op_nxt = (st == ST_EWR) ? OP_EWRITE :
                                 (st == ST_DWR) ? OP_DWRITE : OP_RMW;
                    hid_n      = 1'b0;
                    st_n       = any_cas ? ST_CAS_HOLD : ST_IDLE;
                end else begin
                    col_take = any_cas & ~cas_prev;
                end
            end
            ST_CAS_PRE: begin
                if (ras_a) begin
                    st_n = ST_CBR;
                end else if (!any_cas) begin
                    rpt_fire   = 1'b1;
                    rpt_op_nxt = OP_ERROR;
                    st_n       = ST_IDLE;
                end
            end
            ST_CAS_HOLD: begin
                if (ras_a)         st_n = hid ? ST_HIDDEN : ST_CBR;
                else if (!any_cas) st_n = ST_IDLE;
            end
            ST_CBR, ST_HIDDEN: begin
                if (!ras_a) begin
                    rpt_fire   = 1'b1;
                    rpt_op_nxt = (st == ST_HIDDEN) ? OP_HIDDEN : OP_CBR;
                    hid_n      = (st == ST_HIDDEN);
                    st_n       = any_cas ? ST_CAS_HOLD : ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // Sequencer state, flags and registered report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            hid       <= 1'b0;
            oe_seen   <= 1'b0;
            cas_prev  <= 1'b0;
            rpt_valid <= 1'b0;
            rpt_op    <= OP_STANDBY;
        end else begin
            st        <= st_n;
            hid       <= hid_n;
            oe_seen   <= oes_n;
            cas_prev  <= any_cas;
            rpt_valid <= rpt_fire;
            if (rpt_fire) rpt_op <= rpt_op_nxt;
        end
    end

    // Live operation code and lane-phase flags from the state.
    always_comb begin
        case (st)
            ST_ROW:    cur_op = OP_ROW_OPEN;
            ST_READ:   cur_op = OP_READ;
            ST_EWR:    cur_op = OP_EWRITE;
            ST_DWR:    cur_op = OP_DWRITE;
            ST_RMW:    cur_op = OP_RMW;
            ST_CBR:    cur_op = OP_CBR;
            ST_HIDDEN: cur_op = OP_HIDDEN;
            default:   cur_op = OP_STANDBY;
        endcase
        st_col = (st == ST_READ) || (st == ST_EWR) || (st == ST_DWR) ||
                 (st == ST_RMW)  || (st == ST_HIDDEN);
        st_out = (st == ST_READ) || (st == ST_HIDDEN);
        st_in  = (st == ST_EWR)  || (st == ST_DWR) || (st == ST_RMW);
    end

    // R11: a report is a single-cycle pulse.
    p_rpt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);

    // R11: a non-error report follows the row strobe going inactive.
    p_rpt_on_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_op != OP_ERROR) |-> !$past(ras_a));

    // R10: an error report only arises with the row strobe inactive
    // and every column strobe released.
    p_err_ras_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_op == OP_ERROR) |-> (!$past(ras_a) && !$past(any_cas)));

endmodule

// File: rtl/dsd_addr_capture.sv
// Row/column address latches and the address fields of the report.
// Assumes: take strobes come from the sequencer in the same cycle as
// the matching synchronized address sample.
module dsd_addr_capture
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              row_take,
    input  logic              col_take,
    input  logic              rpt_fire,
    input  op_e               rpt_op_nxt,
    output logic [ROW_W-1:0]  rpt_row,
    output logic [COL_W-1:0]  rpt_col
);

    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic             keep_row, keep_col;

    // Which reported operations carry which address fields.
    always_comb begin
        keep_col = (rpt_op_nxt == OP_READ)   || (rpt_op_nxt == OP_EWRITE) ||
                   (rpt_op_nxt == OP_DWRITE) || (rpt_op_nxt == OP_RMW);
        keep_row = keep_col || (rpt_op_nxt == OP_RAS_ONLY);
    end

    // Latch row at row-strobe fall and column at each new column fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
        end else begin
            if (row_take) begin
                row_q <= addr_s[ROW_W-1:0];
                col_q <= '0;
            end
            if (col_take) col_q <= addr_s[COL_W-1:0];
        end
    end

    // Register the report address fields at the report event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_row <= '0;
            rpt_col <= '0;
        end else if (rpt_fire) begin
            rpt_row <= keep_row ? row_q : '0;
            rpt_col <= keep_col ? col_q : '0;
        end
    end

endmodule

// File: rtl/dsd_lane_ctrl.sv
// Per-lane enable, drive and write-sample outputs.
// Assumes: lane i follows column strobe i only; phase flags come from
// the sequencer.
module dsd_lane_ctrl #(
    parameter int NL = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] cas_a,
    input  logic          oe_a,
    input  logic          st_col,
    input  logic          st_out,
    input  logic          st_in,
    output logic [NL-1:0] lane_en,
    output logic [NL-1:0] dq_oe,
    output logic [NL-1:0] dq_din
);

    for (genvar i = 0; i < NL; i++) begin : g_lane
        // Gate each lane by its own column strobe and the cycle phase.
        always_comb begin
            lane_en[i] = st_col & cas_a[i];
            dq_oe[i]   = lane_en[i] & st_out & oe_a;
            dq_din[i]  = lane_en[i] & st_in;
        end

        // R7: a lane is never driven and sampled at once.
        p_io_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(dq_oe[i] && dq_din[i]));
    end

endmodule

// File: rtl/dram_strobe_decoder.sv
// Top of the strobe-sequence decoder: synchronizes the active-low
// strobes and the address, then runs the sequencer, address latches
// and lane control.
// Assumes: lane 0 is the low byte (lcas_n), lane 1 the high byte.
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [3:0]        cur_op,
    output logic [1:0]        lane_en,
    output logic [1:0]        dq_oe,
    output logic [1:0]        dq_din,
    output logic              rpt_valid,
    output logic [3:0]        rpt_op,
    output logic [ROW_W-1:0]  rpt_row,
    output logic [COL_W-1:0]  rpt_col
);

    localparam int NL    = 2;
    localparam int NSTRB = NL + 3;

    logic [NSTRB-1:0]  strb_raw, strb_s;
    logic [ADDR_W-1:0] addr_s;
    logic              ras_a, we_a, oe_a;
    logic [NL-1:0]     cas_a;
    op_e               cur_op_e, rpt_op_e, rpt_op_nxt;
    logic              row_take, col_take, st_col, st_out, st_in, rpt_fire;

    assign strb_raw = {oe_n, we_n, ucas_n, lcas_n, ras_n};

    dsd_sync #(.W(NSTRB), .RST_VAL({NSTRB{1'b1}})) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s)
    );

    dsd_sync #(.W(ADDR_W), .RST_VAL({ADDR_W{1'b0}})) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s)
    );

    // Convert synchronized active-low strobes to active-high.
    always_comb begin
        ras_a = ~strb_s[0];
        cas_a = ~strb_s[NL:1];
        we_a  = ~strb_s[NL+1];
        oe_a  = ~strb_s[NL+2];
    end

    dsd_seq_fsm #(.NL(NL)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ras_a(ras_a), .cas_a(cas_a), .we_a(we_a), .oe_a(oe_a),
        .cur_op(cur_op_e), .row_take(row_take), .col_take(col_take),
        .st_col(st_col), .st_out(st_out), .st_in(st_in),
        .rpt_fire(rpt_fire), .rpt_op_nxt(rpt_op_nxt),
        .rpt_valid(rpt_valid), .rpt_op(rpt_op_e)
    );

    dsd_addr_capture #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .addr_s(addr_s),
        .row_take(row_take), .col_take(col_take),
        .rpt_fire(rpt_fire), .rpt_op_nxt(rpt_op_nxt),
        .rpt_row(rpt_row), .rpt_col(rpt_col)
    );

    dsd_lane_ctrl #(.NL(NL)) u_lane (
        .clk(clk), .rst_n(rst_n), .cas_a(cas_a), .oe_a(oe_a),
        .st_col(st_col), .st_out(st_out), .st_in(st_in),
        .lane_en(lane_en), .dq_oe(dq_oe), .dq_din(dq_din)
    );

    assign cur_op = cur_op_e;
    assign rpt_op = rpt_op_e;

    // R1: standby leaves every lane open.
    p_standby_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == 4'd0) |-> (dq_oe == 2'b00 && dq_din == 2'b00));

    // R5: early write never drives the bus.
    p_ewrite_nodrive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_op == 4'd2) |-> (dq_oe == 2'b00));

    // R2: a row-only refresh report carries no column.
    p_rasonly_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_op == 4'd5) |-> (rpt_col == '0));

    // R3: a column-before-row refresh report carries no address.
    p_cbr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_op == 4'd6) |-> (rpt_row == '0 && rpt_col == '0));

endmodule

// File: tb/dram_strobe_decoder_bench.sv
`timescale 1ns/1ps
module dram_strobe_decoder_bench;

    localparam int ADDR_W = 13;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 11;
    localparam int SETTLE = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1;
    logic              we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        cur_op, rpt_op;
    logic [1:0]        lane_en, dq_oe, dq_din;
    logic              rpt_valid;
    logic [ROW_W-1:0]  rpt_row;
    logic [COL_W-1:0]  rpt_col;

    int errors = 0;
    int checks = 0;
    int rpt_cnt = 0;
    int cyc = 0;
    logic [3:0]       last_op;
    logic [ROW_W-1:0] last_row;
    logic [COL_W-1:0] last_col;

    dram_strobe_decoder #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dram_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .cur_op(cur_op), .lane_en(lane_en),
        .dq_oe(dq_oe), .dq_din(dq_din), .rpt_valid(rpt_valid), .rpt_op(rpt_op),
        .rpt_row(rpt_row), .rpt_col(rpt_col)
    );

    always #10 clk = ~clk;

    // Report monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && rpt_valid) begin
            rpt_cnt  <= rpt_cnt + 1;
            last_op  <= rpt_op;
            last_row <= rpt_row;
            last_col <= rpt_col;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic idle_all();
        @(negedge clk);
        ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 reset op", cur_op, 0);
        chk("R1 reset oe", dq_oe, 0);
        chk("R1 reset din", dq_din, 0);
        chk("R11 reset no report", rpt_valid, 0);
    endtask

    task automatic t_ras_only();
        int n0 = rpt_cnt;
        @(negedge clk); addr = 13'h1A5C; ras_n = 0; settle();
        chk("R12 row open", cur_op, 8);
        chk("R9 no lanes", lane_en, 0);
        @(negedge clk); addr = 13'h0777; ras_n = 1; settle();
        chk("R2 report count", rpt_cnt - n0, 1);
        chk("R2 op", last_op, 5);
        chk("R2 row", last_row, 13'h1A5C);
        chk("R2 col", last_col, 0);
    endtask

    task automatic t_read_both();
        @(negedge clk); addr = 13'h0123; ras_n = 0; settle();
        @(negedge clk); addr = 13'h02AB; lcas_n = 0; ucas_n = 0; oe_n = 0; settle();
        chk("R4 op", cur_op, 1);
        chk("R4 drive", dq_oe, 2'b11);
        chk("R4 din", dq_din, 0);
        @(negedge clk); oe_n = 1; settle();
        chk("R4 oe off no drive", dq_oe, 0);
        @(negedge clk); ras_n = 1; lcas_n = 1; ucas_n = 1; settle();
        chk("R11 read op", last_op, 1);
        chk("R11 read row", last_row, 13'h0123);
        chk("R11 read col", last_col, 11'h2AB);
        chk("R1 after read", cur_op, 0);
    endtask

    task automatic t_lane_upper();
        @(negedge clk); addr = 13'h0042; ras_n = 0; settle();
        @(negedge clk); addr = 13'h0011; ucas_n = 0; oe_n = 0; settle();
        chk("R9 upper lane", lane_en, 2'b10);
        chk("R9 upper drive", dq_oe, 2'b10);
        // new column by a second strobe pulse (page access)
        @(negedge clk); ucas_n = 1; settle();
        chk("R9 lane released", lane_en, 0);
        @(negedge clk); addr = 13'h0033; lcas_n = 0; settle();
        chk("R9 lower lane", lane_en, 2'b01);
        chk("R9 lower drive", dq_oe, 2'b01);
        @(negedge clk); ras_n = 1; lcas_n = 1; oe_n = 1; settle();
        chk("R11 page col", last_col, 11'h033);
    endtask

    task automatic t_early_write();
        @(negedge clk); addr = 13'h0F00; ras_n = 0; settle();
        @(negedge clk); addr = 13'h0055; we_n = 0; lcas_n = 0; settle();
        chk("R5 op", cur_op, 2);
        chk("R5 no drive", dq_oe, 0);
        chk("R5 din", dq_din, 2'b01);
        @(negedge clk); ras_n = 1; lcas_n = 1; we_n = 1; settle();
        chk("R5 report", last_op, 2);
        chk("R11 ew col", last_col, 11'h055);
    endtask

    task automatic t_delayed_write();
        @(negedge clk); addr = 13'h0ABC; ras_n = 0; settle();
        @(negedge clk); addr = 13'h0066; lcas_n = 0; ucas_n = 0; settle();
        chk("R6 read first", cur_op, 1);
        @(negedge clk); we_n = 0; settle();
        chk("R6 op", cur_op, 3);
        chk("R6 no drive", dq_oe, 0);
        @(negedge clk); ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; settle();
        chk("R6 report", last_op, 3);
    endtask

    task automatic t_rmw();
        @(negedge clk); addr = 13'h0321; ras_n = 0; settle();
        @(negedge clk); addr = 13'h0007; lcas_n = 0; ucas_n = 0; oe_n = 0; settle();
        chk("R7 read phase drive", dq_oe, 2'b11);
        @(negedge clk); oe_n = 1; settle();
        @(negedge clk); we_n = 0; settle();
        chk("R7 op", cur_op, 4);
        chk("R7 no drive", dq_oe, 0);
        chk("R7 din", dq_din, 2'b11);
        @(negedge clk); ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; settle();
        chk("R7 report", last_op, 4);
    endtask

    task automatic t_hidden();
        int n0;
        @(negedge clk); addr = 13'h0444; ras_n = 0; settle();
        @(negedge clk); addr = 13'h0022; lcas_n = 0; ucas_n = 0; oe_n = 0; settle();
        @(negedge clk); ras_n = 1; settle();
        chk("R8 read reported", last_op, 1);
        chk("R1 held cas standby", cur_op, 0);
        chk("R1 held cas open", dq_oe, 0);
        @(negedge clk); addr = 13'h1FFF; ras_n = 0; settle();
        chk("R8 op", cur_op, 7);
        chk("R8 drive", dq_oe, 2'b11);
        @(negedge clk); ras_n = 1; settle();
        chk("R8 report", last_op, 7);
        chk("R8 row zero", last_row, 0);
        n0 = rpt_cnt;
        @(negedge clk); lcas_n = 1; ucas_n = 1; oe_n = 1; settle();
        chk("R8 no error on release", rpt_cnt - n0, 0);
    endtask

    task automatic t_cbr();
        @(negedge clk); addr = 13'h1234; lcas_n = 0; settle();
        chk("R1 cas only standby", cur_op, 0);
        @(negedge clk); ras_n = 0; settle();
        chk("R3 op", cur_op, 6);
        chk("R3 open", dq_oe, 0);
        chk("R3 no din", dq_din, 0);
        @(negedge clk); ras_n = 1; lcas_n = 1; settle();
        chk("R3 report", last_op, 6);
        chk("R3 row ignored", last_row, 0);
        chk("R3 col ignored", last_col, 0);
    endtask

    task automatic t_error();
        int n0 = rpt_cnt;
        @(negedge clk); ucas_n = 0; we_n = 0; settle();
        @(negedge clk); ucas_n = 1; settle();
        chk("R10 one report", rpt_cnt - n0, 1);
        chk("R10 error code", last_op, 15);
        chk("R1 after error", cur_op, 0);
        @(negedge clk); we_n = 1; settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        settle();
        t_reset();
        t_ras_only();      idle_all();
        t_read_both();     idle_all();
        t_lane_upper();    idle_all();
        t_early_write();   idle_all();
        t_delayed_write(); idle_all();
        t_rmw();           idle_all();
        t_hidden();        idle_all();
        t_cbr();           idle_all();
        t_error();         idle_all();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule